// File: doc/BRIEF.md
# Low-Power Hold Sequencer for a Synchronous Memory

This block gates a synchronous memory in and out of a low-power hold state. A request line arrives from outside the clock domain. It goes high to ask for the hold state and low to leave it. If the line is left undriven, it counts as low. The request is resynchronised, and the block then steps through a fixed entry phase into the hold state. While the memory is held, its contents stay intact. When the request is withdrawn, the block steps through a fixed exit phase and then a recovery window before normal traffic may resume.

Around the memory, the block drives three signals. The first is a gate that says whether an access may start. The second is a disable for the data outputs. The third is a flag showing that the memory is fully held. Two kinds of misuse raise a sticky violation flag, which only a reset clears. The first is asking for the hold state while the memory is still selected. The second is attempting an access during the recovery window. Neither misuse changes the sequence: the hold state is still entered, and the attempted access is still refused.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: During and after reset the block is in the awake state. In that state `access_ok`=1, `out_disable`=0, `asleep`=0 and `violation`=0.
- R2: `sleep_req` passes through SYNC_STAGES (default 2) flip-flops before the sequencer acts on it. After the request rises, `access_ok` stays 1 for two more clock edges and drops after the third.
- R3: Entry takes ENTRY_CYCLES (default 2) cycles. `asleep` rises ENTRY_CYCLES edges after `access_ok` falls.
- R4: Whenever the block is not awake, `access_ok`=0 and `out_disable`=1. An access pending at the start of entry is dropped.
- R5: After the synchronised request falls, `asleep` drops. The exit phase then lasts EXIT_CYCLES (default 2) cycles and recovery lasts RECOVERY_CYCLES (default 2) cycles. `access_ok` returns to 1 no earlier than EXIT_CYCLES+RECOVERY_CYCLES edges after `asleep` falls.
- R6: An `acc_start` during the recovery window is ignored: `access_ok` stays 0 and the window is not lengthened. The same `acc_start` sets `violation` on the following edge.
- R7: If the sequencer begins entry while `deselected`=0, `violation` is set, and the hold state is still reached on schedule.
- R8: Once `violation` is 1, it stays 1 until reset.
- R9: If the request is withdrawn during entry, entry still completes. The block then holds for at least one cycle and exits through the normal exit and recovery sequence.
- R10: An `acc_start` outside the recovery window never sets `violation`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Asynchronous hold request, active high |
| deselected | input | 1 | 1 when the memory is currently not selected |
| acc_start | input | 1 | An access start (strobe with chip enables) is being attempted |
| asleep | output | 1 | Memory is fully in the hold state |
| access_ok | output | 1 | A new access may start |
| out_disable | output | 1 | Data outputs must be held off |
| violation | output | 1 | Sticky protocol-violation flag |

## Verification
The bench builds the block with all default values: two synchroniser stages, and two cycles each for entry, exit and recovery. With these short windows, every phase boundary is reached within a handful of cycles. This allows the edge-exact checks on when `access_ok` falls, when `asleep` rises and falls, and when the gate reopens. It also allows the short-pulse case, where the request drops while entry is still under way. The reference model takes the same parameter values, so its phase lengths follow whatever the block is built with.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE   = 3'd0,
        ST_ENTER   = 3'd1,
        ST_HOLD    = 3'd2,
        ST_EXIT    = 3'd3,
        ST_RECOVER = 3'd4
    } slp_state_e;

    typedef struct packed {
        logic asleep;
        logic access_ok;
        logic out_disable;
    } slp_flags_t;

    function automatic slp_flags_t flags_of(slp_state_e s);
        slp_flags_t f;
        f.asleep      = (s == ST_HOLD);
        f.access_ok   = (s == ST_AWAKE);
        f.out_disable = (s != ST_AWAKE);
        return f;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sleep_phase_timer.sv
module sleep_phase_timer #(
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
    import sleep_seq_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int ENTRY_CYCLES    = 2,
    parameter int EXIT_CYCLES     = 2,
    parameter int RECOVERY_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic deselected,
    input  logic acc_start,
    output logic asleep,
    output logic access_ok,
    output logic out_disable,
    output logic violation
);
    localparam int MAXC = max3(ENTRY_CYCLES, EXIT_CYCLES, RECOVERY_CYCLES);
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0] LD_ENTRY = TW'(ENTRY_CYCLES - 1);
    localparam logic [TW-1:0] LD_EXIT  = TW'(EXIT_CYCLES - 1);
    localparam logic [TW-1:0] LD_REC   = TW'(RECOVERY_CYCLES - 1);

    slp_state_e    st, st_nxt;
    logic          req_s;
    logic          t_load, t_expired;
    logic [TW-1:0] t_val;
    logic          set_viol;
    logic          viol_q;
    slp_flags_t    flags;

    sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (sleep_req),
        .dout (req_s)
    );

    sleep_phase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    always_comb begin
        st_nxt   = st;
        t_load   = 1'b0;
        t_val    = '0;
        set_viol = 1'b0;
        case (st)
            ST_AWAKE: begin
                if (req_s) begin
                    st_nxt   = ST_ENTER;
                    t_load   = 1'b1;
                    t_val    = LD_ENTRY;
                    set_viol = !deselected;
                end
            end
            ST_ENTER: begin
                if (t_expired) st_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (!req_s) begin
                    st_nxt = ST_EXIT;
                    t_load = 1'b1;
                    t_val  = LD_EXIT;
                end
            end
            ST_EXIT: begin
                if (t_expired) begin
                    st_nxt = ST_RECOVER;
                    t_load = 1'b1;
                    t_val  = LD_REC;
                end
            end
            ST_RECOVER: begin
                set_viol = acc_start;
                if (t_expired) st_nxt = ST_AWAKE;
            end
            default: st_nxt = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_AWAKE;
            viol_q <= 1'b0;
        end else begin
            st     <= st_nxt;
            viol_q <= viol_q | set_viol;
        end
    end

    assign flags       = flags_of(st);
    assign asleep      = flags.asleep;
    assign access_ok   = flags.access_ok;
    assign out_disable = flags.out_disable;
    assign violation   = viol_q;
endmodule

// File: rtl/sleep_seq_ctrl_chk.sv
module sleep_seq_ctrl_chk
    import sleep_seq_pkg::*;
#(
    parameter int EXIT_CYCLES     = 2,
    parameter int RECOVERY_CYCLES = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       deselected,
    input logic       acc_start,
    input logic       asleep,
    input logic       access_ok,
    input logic       out_disable,
    input logic       violation,
    input logic       req_s,
    input slp_state_e st
);
    localparam int GAP = EXIT_CYCLES + RECOVERY_CYCLES;
    localparam int GW  = $clog2(GAP + 1) + 1;

    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst)                      gap_cnt <= GW'(GAP);
        else if (asleep)              gap_cnt <= '0;
        else if (gap_cnt < GW'(GAP))  gap_cnt <= gap_cnt + 1'b1;
    end

    AST_HOLD_GATED: assert property (@(posedge clk) disable iff (rst)
        asleep |-> (!access_ok && out_disable));                          // R4
    AST_GATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        access_ok |-> !out_disable);                                      // R4
    AST_ENTRY_MIN: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> $past(out_disable));                            // R3
    AST_RECOVERY_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(access_ok) |-> (gap_cnt >= GW'(GAP)));                      // R5
    AST_RECOVER_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RECOVER && acc_start) |=> violation);                   // R6
    AST_SELECTED_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_AWAKE && req_s && !deselected) |=> violation);          // R7
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
        violation |=> violation);                                         // R8
endmodule

bind sleep_seq_ctrl sleep_seq_ctrl_chk #(
    .EXIT_CYCLES     (EXIT_CYCLES),
    .RECOVERY_CYCLES (RECOVERY_CYCLES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .deselected  (deselected),
    .acc_start   (acc_start),
    .asleep      (asleep),
    .access_ok   (access_ok),
    .out_disable (out_disable),
    .violation   (violation),
    .req_s       (req_s),
    .st          (st)
);

// File: tb/sim_sleep_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sleep_seq_ctrl;
    localparam int SYNC = 2, ENT = 2, EXT = 2, REC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0, deselected = 1'b1, acc_start = 1'b0;
    logic asleep, access_ok, out_disable, violation;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    sleep_seq_ctrl #(
        .SYNC_STAGES(SYNC), .ENTRY_CYCLES(ENT),
        .EXIT_CYCLES(EXT), .RECOVERY_CYCLES(REC)
    ) u0 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .deselected(deselected),
        .acc_start(acc_start), .asleep(asleep), .access_ok(access_ok),
        .out_disable(out_disable), .violation(violation)
    );

    // Behavioural reference: phase 0 awake, 1 entering, 2 held, 3 leaving, 4 recovering
    int  m_phase = 0, m_cnt = 0;
    bit  m_viol = 0;
    bit  m_seen[$];

    always @(posedge clk) begin
        bit seen;
        cyc++;
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_viol = 0;
            m_seen = {};
            for (int i = 0; i < SYNC; i++) m_seen.push_back(1'b0);
        end else begin
            seen = m_seen[SYNC-1];
            case (m_phase)
                0: if (seen) begin
                       if (!deselected) m_viol = 1;
                       m_phase = 1; m_cnt = 0;
                   end
                1: begin m_cnt++; if (m_cnt == ENT) m_phase = 2; end
                2: if (!seen) begin m_phase = 3; m_cnt = 0; end
                3: begin m_cnt++; if (m_cnt == EXT) begin m_phase = 4; m_cnt = 0; end end
                default: begin
                    if (acc_start) m_viol = 1;
                    m_cnt++; if (m_cnt == REC) m_phase = 0;
                end
            endcase
            m_seen.push_front(sleep_req);
            void'(m_seen.pop_back());
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic cmp_model();
        chk("R3 asleep",      asleep,      m_phase == 2);
        chk("R4 access_ok",   access_ok,   m_phase == 0);
        chk("R5 out_disable", out_disable, m_phase != 0);
        chk("R8 violation",   violation,   m_viol);
    endtask

    // advance n edges; compare against the model at each falling edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!rst) cmp_model();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sleep_req = 1'b0; deselected = 1'b1; acc_start = 1'b0;
        step(3);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        wait (cyc > 20000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 access_ok", access_ok, 1'b1);
        chk("R1 out_disable", out_disable, 1'b0);
        chk("R1 asleep", asleep, 1'b0);
        chk("R1 violation", violation, 1'b0);

        // R10 accesses while awake do not flag
        acc_start = 1'b1; step(3); acc_start = 1'b0; step(1);
        chk("R10 violation", violation, 1'b0);

        // clean entry and exit
        sleep_req = 1'b1; acc_start = 1'b1;
        step(2);
        chk("R2 access_ok", access_ok, 1'b1);
        step(1); acc_start = 1'b0;
        chk("R4 access_ok", access_ok, 1'b0);
        chk("R4 out_disable", out_disable, 1'b1);
        chk("R3 asleep early", asleep, 1'b0);
        step(ENT);
        chk("R3 asleep", asleep, 1'b1);
        acc_start = 1'b1; step(4); acc_start = 1'b0;
        chk("R10 held access", violation, 1'b0);
        sleep_req = 1'b0;
        step(2);
        chk("R2 asleep", asleep, 1'b1);
        step(1);
        chk("R5 asleep", asleep, 1'b0);
        chk("R5 out_disable", out_disable, 1'b1);
        step(EXT + REC - 1);
        chk("R5 access_ok", access_ok, 1'b0);
        step(1);
        chk("R5 access_ok", access_ok, 1'b1);
        chk("R5 out_disable", out_disable, 1'b0);
        chk("R10 violation", violation, 1'b0);

        // R6 access during recovery
        sleep_req = 1'b1; step(SYNC + 1 + ENT + 2);
        sleep_req = 1'b0; step(SYNC + 1 + EXT);
        acc_start = 1'b1; step(1); acc_start = 1'b0;
        chk("R6 access_ok", access_ok, 1'b0);
        chk("R6 violation", violation, 1'b1);
        step(REC - 1);
        chk("R6 window", access_ok, 1'b1);
        step(10);
        chk("R8 violation", violation, 1'b1);

        // R7 entry while selected
        do_reset();
        chk("R8 cleared", violation, 1'b0);
        deselected = 1'b0; sleep_req = 1'b1;
        step(SYNC + 1);
        chk("R7 violation", violation, 1'b1);
        deselected = 1'b1;
        step(ENT);
        chk("R7 asleep", asleep, 1'b1);
        sleep_req = 1'b0; step(SYNC + 1 + EXT + REC + 2);

        // R9 short request dropped during entry
        do_reset();
        sleep_req = 1'b1; step(SYNC + 1);
        sleep_req = 1'b0;
        step(ENT);
        chk("R9 asleep", asleep, 1'b1);
        step(1);
        chk("R9 leaving", asleep, 1'b0);
        step(EXT + REC);
        chk("R9 access_ok", access_ok, 1'b1);
        chk("R9 violation", violation, 1'b0);
        step(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule